// File: doc/BRIEF.md
# Multichannel auxiliary ADC controller

This block is a register-mapped front end for one shared successive-approximation converter that serves sixteen analog inputs. Software asks for a sample on a channel by raising that channel's bit in a trigger register. The controller records the request and hands the converter one channel at a time through a start/channel/done/data handshake. When the sample comes back it lands in that channel's result word together with a ready flag.

A status bit tells software whether the converter still has work, either in flight or waiting. A power-enable bit in a control word gates the sequencer. While that bit is low, requests are kept but no conversion begins. A typical driver clears the channel's trigger bit and checks that the ready flag has gone. It then sets the bit again and polls the ready flag or the busy bit.

Top module: `auxadc_ctrl`

## Requirements
- R1: After reset, the trigger word, the control word, the status word and every result word read 0, and no start pulse is issued.
- R2: The trigger word is at word address 1 (byte offset 0x04). Bit n belongs to channel n, and the last value written reads back.
- R3: A write that takes trigger bit n from 0 to 1 requests one conversion of channel n. That conversion appears as a one-cycle `cnv_start` with `cnv_chan` = n. Writing 1 to a bit that is already 1 requests nothing.
- R4: Channel n's result word is at word address 5+n (byte offset 0x14+4n). Bits 11:0 hold the last sample and bit 12 is the ready flag. Both are updated by the clock edge that samples `cnv_done`.
- R5: A trigger-word write with bit n = 0 clears channel n's ready flag and leaves its sample in place. If a done for channel n arrives in the same cycle, the fresh sample wins and the flag reads 1.
- R6: Status bit 0, at word address 4 (byte offset 0x10), reads 1 while a conversion runs or any request is pending, and reads 0 otherwise.
- R7: The power-enable bit is bit 14 of the control word at word address 37 (byte offset 0x94). While it is 0 no start is issued and pending requests are kept. Once it is 1 they are served.
- R8: Pending requests are served one at a time, lowest channel number first. No start is issued while a conversion is in flight.
- R9: A trigger edge is never lost. This holds when it arrives during a conversion, and when it arrives for channel n in the very cycle that a pending request of channel n is being started. In that second case channel n is converted again afterwards.
- R10: Reads of unmapped word addresses return 0 and writes to them have no effect. Result words and the status word are read-only.
- R11: With power on and the converter idle, `cnv_start` is visible in the cycle after the triggering write. The ready flag reads 1 in the cycle after the done pulse, so a sample completes within the converter latency plus 3 cycles, far inside 25 microseconds at 50 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the addressed word, one cycle |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| cnv_start | output | 1 | One-cycle request to the converter |
| cnv_chan | output | 4 | Channel to convert, valid with `cnv_start` |
| cnv_done | input | 1 | One-cycle completion from the converter |
| cnv_data | input | 12 | Sample, valid with `cnv_done` |

## Verification
Two collisions can fall in the same cycle. The first is a software trigger edge for a channel landing in the cycle when the arbiter starts that same channel's older request. The bench provokes it by leaving a request pending with power off and the trigger bit low. It then turns power on and writes the bit high in the exact cycle when `cnv_start` shows. The outcome is judged by counting the starts of that channel, which must be two. The second collision is a ready-clearing write landing with the converter's done pulse. The bench waits for `cnv_done` and writes the trigger word to zero in that cycle, and the ready flag must still read 1.

// File: rtl/auxadc_pkg.sv
package auxadc_pkg;
  localparam int BUS_W    = 32;
  localparam int TRIG_WA  = 1;
  localparam int STAT_WA  = 4;
  localparam int RES0_WA  = 5;
  localparam int CTRL_WA  = 37;
  localparam int PWR_BIT  = 14;
  localparam int RDY_BIT  = 12;

  typedef enum logic {SEQ_IDLE, SEQ_CONV} seq_state_e;

  function automatic logic [BUS_W-1:0] pack_result(logic [BUS_W-1:0] samp, logic rdy);
    logic [BUS_W-1:0] r;
    r = samp;
    r[RDY_BIT] = rdy;
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] pack_ctrl(logic pwr);
    logic [BUS_W-1:0] r;
    r = '0;
    r[PWR_BIT] = pwr;
    return r;
  endfunction
endpackage

// File: rtl/auxadc_regs.sv
module auxadc_regs #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_trig,
  input  logic              wr_ctrl,
  input  logic [NUM_CH-1:0] trig_wdata,
  input  logic              pwr_wdata,
  output logic [NUM_CH-1:0] trig_q,
  output logic              pwr_en,
  output logic [NUM_CH-1:0] rise_vec,
  output logic [NUM_CH-1:0] clr_vec
);
  always_comb begin
    rise_vec = wr_trig ? (trig_wdata & ~trig_q) : '0;
    clr_vec  = wr_trig ? ~trig_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      pwr_en <= 1'b0;
    end else begin
      if (wr_trig) trig_q <= trig_wdata;
      if (wr_ctrl) pwr_en <= pwr_wdata;
    end
  end
endmodule

// File: rtl/auxadc_arb.sv
module auxadc_arb #(
  parameter  int NUM_CH = 16,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic              take,
  input  logic [CH_W-1:0]   take_ch,
  output logic [NUM_CH-1:0] pend_q,
  output logic              grant_valid,
  output logic [CH_W-1:0]   grant_ch
);
  function automatic logic [CH_W-1:0] lowest_set(logic [NUM_CH-1:0] v);
    logic [CH_W-1:0] idx;
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (v[i]) idx = CH_W'(i);
    return idx;
  endfunction

  logic [NUM_CH-1:0] take_mask;

  always_comb begin
    grant_valid = |pend_q;
    grant_ch    = lowest_set(pend_q);
    take_mask   = take ? (NUM_CH'(1) << take_ch) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~take_mask) | set_vec;
  end
endmodule

// File: rtl/auxadc_seq.sv
module auxadc_seq #(
  parameter  int NUM_CH = 16,
  parameter  int SAMP_W = 12,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic              grant_valid,
  input  logic [CH_W-1:0]   grant_ch,
  input  logic              cnv_done,
  input  logic [SAMP_W-1:0] cnv_data,
  output logic              cnv_start,
  output logic [CH_W-1:0]   cnv_chan,
  output logic              inflight,
  output logic              res_wr,
  output logic [CH_W-1:0]   res_ch,
  output logic [SAMP_W-1:0] res_data
);
  import auxadc_pkg::*;

  seq_state_e      state_q;
  logic [CH_W-1:0] cur_ch_q;

  always_comb begin
    inflight  = (state_q == SEQ_CONV);
    cnv_start = !inflight && pwr_en && grant_valid;
    cnv_chan  = grant_ch;
    res_wr    = inflight && cnv_done;
    res_ch    = cur_ch_q;
    res_data  = cnv_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      cur_ch_q <= '0;
    end else begin
      if (cnv_start) begin
        state_q  <= SEQ_CONV;
        cur_ch_q <= grant_ch;
      end else if (res_wr) begin
        state_q  <= SEQ_IDLE;
      end
    end
  end
endmodule

// File: rtl/auxadc_results.sv
module auxadc_results #(
  parameter  int NUM_CH = 16,
  parameter  int SAMP_W = 12,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          res_wr,
  input  logic [CH_W-1:0]               res_ch,
  input  logic [SAMP_W-1:0]             res_data,
  input  logic [NUM_CH-1:0]             clr_vec,
  output logic [NUM_CH-1:0][SAMP_W-1:0] data_q,
  output logic [NUM_CH-1:0]             rdy_q
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = res_wr && (res_ch == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[g] <= '0;
        rdy_q[g]  <= 1'b0;
      end else if (hit) begin
        data_q[g] <= res_data;
        rdy_q[g]  <= 1'b1;
      end else if (clr_vec[g]) begin
        rdy_q[g]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/auxadc_ctrl.sv
module auxadc_ctrl #(
  parameter  int NUM_CH = 16,
  parameter  int SAMP_W = 12,
  parameter  int ADDR_W = 6,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cnv_start,
  output logic [CH_W-1:0]   cnv_chan,
  input  logic              cnv_done,
  input  logic [SAMP_W-1:0] cnv_data
);
  import auxadc_pkg::*;

  logic                          sel_trig, sel_stat, sel_ctrl, sel_res;
  logic [ADDR_W-1:0]             res_ofs;
  logic [CH_W-1:0]               res_idx;
  logic [NUM_CH-1:0]             trig_q, rise_vec, clr_vec, pend_q, rdy_q;
  logic                          pwr_en, grant_valid, inflight, res_wr, busy;
  logic [CH_W-1:0]               grant_ch, res_ch;
  logic [SAMP_W-1:0]             res_data;
  logic [NUM_CH-1:0][SAMP_W-1:0] data_q;
  logic                          unused_wbits;

  assign unused_wbits = ^bus_wdata;

  always_comb begin
    sel_trig = (bus_addr == ADDR_W'(TRIG_WA));
    sel_stat = (bus_addr == ADDR_W'(STAT_WA));
    sel_ctrl = (bus_addr == ADDR_W'(CTRL_WA));
    res_ofs  = bus_addr - ADDR_W'(RES0_WA);
    sel_res  = (bus_addr >= ADDR_W'(RES0_WA)) && (res_ofs < ADDR_W'(NUM_CH));
    res_idx  = res_ofs[CH_W-1:0];
    busy     = inflight || (|pend_q);
  end

  auxadc_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_trig(bus_we && sel_trig), .wr_ctrl(bus_we && sel_ctrl),
    .trig_wdata(bus_wdata[NUM_CH-1:0]), .pwr_wdata(bus_wdata[PWR_BIT]),
    .trig_q(trig_q), .pwr_en(pwr_en), .rise_vec(rise_vec), .clr_vec(clr_vec)
  );

  auxadc_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk(clk), .rst_n(rst_n), .set_vec(rise_vec),
    .take(cnv_start), .take_ch(cnv_chan),
    .pend_q(pend_q), .grant_valid(grant_valid), .grant_ch(grant_ch)
  );

  auxadc_seq #(.NUM_CH(NUM_CH), .SAMP_W(SAMP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en),
    .grant_valid(grant_valid), .grant_ch(grant_ch),
    .cnv_done(cnv_done), .cnv_data(cnv_data),
    .cnv_start(cnv_start), .cnv_chan(cnv_chan), .inflight(inflight),
    .res_wr(res_wr), .res_ch(res_ch), .res_data(res_data)
  );

  auxadc_results #(.NUM_CH(NUM_CH), .SAMP_W(SAMP_W)) u_res (
    .clk(clk), .rst_n(rst_n), .res_wr(res_wr), .res_ch(res_ch),
    .res_data(res_data), .clr_vec(clr_vec), .data_q(data_q), .rdy_q(rdy_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_trig)      bus_rdata = 32'(trig_q);
    else if (sel_stat) bus_rdata = 32'(busy);
    else if (sel_ctrl) bus_rdata = pack_ctrl(pwr_en);
    else if (sel_res)  bus_rdata = pack_result(32'(data_q[res_idx]), rdy_q[res_idx]);
  end
endmodule

// File: rtl/auxadc_ctrl_chk.sv
module auxadc_ctrl_chk #(
  parameter  int NUM_CH = 16,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnv_start,
  input logic [CH_W-1:0]   cnv_chan,
  input logic              pwr_en,
  input logic              inflight,
  input logic              busy,
  input logic [NUM_CH-1:0] pend_q,
  input logic [NUM_CH-1:0] rise_vec,
  input logic [NUM_CH-1:0] rdy_q,
  input logic              res_wr,
  input logic [CH_W-1:0]   res_ch
);
  logic [NUM_CH-1:0] below_mask;
  assign below_mask = (NUM_CH'(1) << cnv_chan) - NUM_CH'(1);

  AST_START_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> pwr_en); // R7
  AST_START_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> pend_q[cnv_chan]); // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> !cnv_start); // R3
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> ((pend_q & below_mask) == '0)); // R8
  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    inflight |-> !cnv_start); // R8
  AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_vec) |=> ((pend_q & $past(rise_vec)) == $past(rise_vec))); // R9
  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |=> rdy_q[$past(res_ch)]); // R4
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> busy); // R6
endmodule

bind auxadc_ctrl auxadc_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_start(cnv_start), .cnv_chan(cnv_chan),
  .pwr_en(pwr_en), .inflight(inflight), .busy(busy), .pend_q(pend_q),
  .rise_vec(rise_vec), .rdy_q(rdy_q), .res_wr(res_wr), .res_ch(res_ch)
);

// File: tb/tb_auxadc_ctrl.sv
`timescale 1ns/1ps
module tb_auxadc_ctrl;
  localparam int CONV_LAT = 10;
  localparam int TRIG = 1, STAT = 4, RES0 = 5, CTRL = 37;
  localparam logic [31:0] PWR_ON = 32'h0000_4000;

  logic clk = 0, rst_n = 0, bus_we = 0, cnv_done = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic cnv_start;
  logic [3:0] cnv_chan;
  logic [11:0] cnv_data = 0;

  int checks = 0, errors = 0, phase = 0, lat = 0, cur_ch = 0, nlog = 0;
  int nstart [16];
  int slog [64];
  bit finished = 0;

  always #10 clk = ~clk;

  auxadc_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnv_start(cnv_start),
    .cnv_chan(cnv_chan), .cnv_done(cnv_done), .cnv_data(cnv_data));

  function automatic logic [11:0] samp_of(int ch, int ph);
    return 12'((ch * 293 + ph * 71 + 5) % 4096);
  endfunction

  function automatic int popc(logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(v[i]);
    return c;
  endfunction

  // converter model, evaluated on the falling edge
  always @(negedge clk) begin
    if (lat == 1) begin cnv_done = 1; cnv_data = samp_of(cur_ch, phase); end
    else cnv_done = 0;
    if (lat > 0) lat--;
    if (rst_n && cnv_start) begin
      cur_ch = int'(cnv_chan);
      lat = CONV_LAT;
      nstart[cur_ch]++;
      slog[nlog % 64] = cur_ch;
      nlog++;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); #1;
    bus_we = 1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 0;
  endtask

  task automatic wr_now(int a, logic [31:0] d);
    bus_we = 1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_addr = 6'(a); #1; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      rd(STAT, s);
      if (s[0] == 0) break;
    end
  endtask

  task automatic clear_counts();
    for (int i = 0; i < 16; i++) nstart[i] = 0;
    nlog = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [15:0] m1, m2;
    int k;
    void'($urandom(32'd4711));
    clear_counts();
    repeat (3) @(negedge clk);
    #1; rst_n = 1;

    // R1 reset state
    rd(TRIG, v); check("R1 trig", v, 0);
    rd(CTRL, v); check("R1 ctrl", v, 0);
    rd(STAT, v); check("R1 stat", v, 0);
    rd(RES0, v); check("R1 res0", v, 0);
    rd(RES0 + 15, v); check("R1 res15", v, 0);
    check("R1 start", 32'(cnv_start), 0);

    // R7 power off holds requests
    wr(TRIG, 32'h80);
    repeat (20) @(negedge clk); #1;
    check("R7 no start unpowered", 32'(nstart[7]), 0);
    rd(STAT, v); check("R6 busy with pending", v, 1);
    wr(CTRL, PWR_ON);
    rd(CTRL, v); check("R7 ctrl readback", v, PWR_ON);
    wait_idle();
    check("R7 served after power", 32'(nstart[7]), 1);
    rd(RES0 + 7, v); check("R4 res7", v, 32'h1000 | 32'(samp_of(7, phase)));

    // R11 latency, R3 start pulse
    wr(TRIG, 0);
    clear_counts();
    wr(TRIG, 32'h20);
    check("R11 start next cycle", 32'(cnv_start), 1);
    check("R3 start channel", 32'(cnv_chan), 5);
    rd(STAT, v); check("R6 busy converting", v, 1);
    k = 0;
    for (int i = 0; i < 200; i++) begin
      rd(RES0 + 5, v);
      if (v[12]) break;
      k++;
      @(negedge clk); #1;
    end
    check("R11 latency bound", 32'(k <= CONV_LAT + 3), 1);
    wait_idle();
    rd(STAT, v); check("R6 idle", v, 0);

    // R3 writing 1 over 1 does nothing
    wr(TRIG, 32'h20);
    repeat (CONV_LAT + 5) @(negedge clk); #1;
    check("R3 no re-trigger on level", 32'(nstart[5]), 1);

    // R5 clear ready keeps sample
    wr(TRIG, 0);
    rd(RES0 + 5, v); check("R5 ready cleared", v, 32'(samp_of(5, phase)));

    // R8 ascending order
    clear_counts();
    wr(TRIG, 32'h8421);
    wait_idle();
    check("R8 count", 32'(nlog), 4);
    check("R8 order0", 32'(slog[0]), 0);
    check("R8 order1", 32'(slog[1]), 5);
    check("R8 order2", 32'(slog[2]), 10);
    check("R8 order3", 32'(slog[3]), 15);

    // R9 edge during conversion of same channel
    wr(TRIG, 0);
    clear_counts();
    wr(TRIG, 32'h8);
    repeat (2) @(negedge clk);
    wr(TRIG, 32'h0);
    wr(TRIG, 32'hA);
    wait_idle();
    check("R9 ch3 twice", 32'(nstart[3]), 2);
    check("R9 ch1 once", 32'(nstart[1]), 1);

    // R9 edge in the same cycle as the grant of that channel
    wr(TRIG, 0);
    wr(CTRL, 0);
    clear_counts();
    wr(TRIG, 32'h1);
    wr(TRIG, 32'h0);
    wr(CTRL, PWR_ON);
    check("R9 grant cycle", 32'(cnv_start), 1);
    wr_now(TRIG, 32'h1);
    wait_idle();
    check("R9 same-cycle edge kept", 32'(nstart[0]), 2);

    // R5 done and clear in the same cycle
    wr(TRIG, 0);
    phase++;
    wr(TRIG, 32'h4);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (cnv_done) break;
    end
    wr_now(TRIG, 0);
    rd(RES0 + 2, v); check("R5 done wins over clear", v, 32'h1000 | 32'(samp_of(2, phase)));
    wr(TRIG, 0);
    rd(RES0 + 2, v); check("R5 later clear", v[12], 0);

    // R10 unmapped and read-only words
    wr(TRIG, 32'h80);
    wait_idle();
    wr(0, 32'hFFFF_FFFF); rd(0, v); check("R10 word0", v, 0);
    wr(2, 32'hFFFF_FFFF); rd(2, v); check("R10 word2", v, 0);
    rd(63, v); check("R10 word63", v, 0);
    rd(RES0 + 16, v); check("R10 past results", v, 0);
    wr(RES0 + 7, 32'h0); rd(RES0 + 7, v);
    check("R10 result read-only", v, 32'h1000 | 32'(samp_of(7, phase)));
    wr(STAT, 32'hFFFF_FFFF); rd(STAT, v); check("R10 status read-only", v, 0);
    rd(TRIG, v); check("R10 trig untouched", v, 32'h80);

    // R2 readback
    wr(TRIG, 0);
    wr(TRIG, 32'hA5C3);
    rd(TRIG, v); check("R2 readback", v, 32'hA5C3);
    wait_idle();

    // random rounds: R3 R4 R8
    for (int r = 0; r < 12; r++) begin
      wr(TRIG, 0);
      phase++;
      clear_counts();
      m1 = 16'($urandom);
      if (m1 == 0) m1 = 16'h1;
      wr(TRIG, 32'(m1));
      wait_idle();
      check("R8 random count", 32'(nlog), 32'(popc(m1)));
      k = 0;
      for (int n = 0; n < 16; n++)
        if (m1[n]) begin
          check("R8 random order", 32'(slog[k]), 32'(n));
          k++;
        end
      for (int n = 0; n < 16; n++) begin
        rd(RES0 + n, v);
        check("R4 random ready", 32'(v[12]), 32'(m1[n]));
        if (m1[n]) check("R4 random data", 32'(v[11:0]), 32'(samp_of(n, phase)));
      end
    end

    // random rounds with edges during conversion: R9
    for (int r = 0; r < 8; r++) begin
      wr(TRIG, 0);
      phase++;
      clear_counts();
      m1 = 16'($urandom) | 16'h1;
      m2 = 16'($urandom) & ~m1;
      wr(TRIG, 32'(m1));
      repeat (3) @(negedge clk);
      wr(TRIG, 32'(m1 | m2));
      wait_idle();
      check("R9 random count", 32'(nlog), 32'(popc(m1 | m2)));
      for (int n = 0; n < 16; n++) begin
        rd(RES0 + n, v);
        check("R9 random ready", 32'(v[12]), 32'(m1[n] | m2[n]));
      end
    end

    summary();
  end
endmodule